// File: doc/BRIEF.md
# Synchronous SRAM Write Cycle Controller

This block is the access control for a small synchronous RAM with one shared data bus, two byte lanes and one parity bit per lane. Each rising clock edge can open an access through either of two address strobes. The first is a processor-style strobe that only captures the address. The second is a controller-style strobe that can also write on the same edge. After an access opens, the block keeps its address so that a write can follow in later cycles.

The write controls are decoded into per-lane write strobes for a parameterized internal array. These controls are a global write, a byte write enable and per-lane selects. Read data is registered at every edge from the address in use. It is put on the bus only while output enable is low and no write has just been done. The shared bus is split into separate input, output and drive-enable signals so that the block needs no tristate cells.

Top module: `ssram_wr_ctl`

## Requirements
- R1: When `gw_n` is low and a write is allowed in that cycle, both lanes are written, whatever `bwe_n` and `byte_sel_n` are.
- R2: When `gw_n` is high, lane L is written only if `bwe_n` is low and `byte_sel_n[L]` is low. With `bwe_n` high nothing is written.
- R3: Lane 0 holds `bus_din[7:0]` and parity bit `bus_din[16]`. Lane 1 holds `bus_din[15:8]` and parity bit `bus_din[17]`. A one-lane write leaves the bits of the other lane unchanged.
- R4: On an edge where `chip_sel` is high and `proc_strb_n` is low, the address is captured and the write inputs are ignored. On each later edge with no strobe, the write inputs write to the captured address.
- R5: On an edge where `chip_sel` is high, `proc_strb_n` is high and `ctrl_strb_n` is low, the presented address is captured. If the write inputs ask for a write, that address is written on the same edge.
- R6: When both strobes are low with `chip_sel` high, the access is treated as processor-strobed. The controller strobe has no effect and nothing is written on that edge.
- R7: `bus_drv` is low for the whole cycle that follows any edge at which a write was done, even when `oe_n` is low.
- R8: `bus_drv` is high only while `oe_n` is low and an access is open. `bus_dout` then shows the content of the address in use at the previous edge, as it was before any write on that edge.
- R9: When `ctrl_strb_n` is low with `chip_sel` low, the access is closed. `bus_drv` stays low and write inputs are ignored until a new access opens. When `proc_strb_n` is low with `chip_sel` low, the strobe is ignored and an open access continues.
- R10: During reset and after its release, with no strobe, `bus_drv` is low and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_sel | input | 1 | Active-high chip select, sampled at the edge |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| addr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| byte_sel_n | input | LANES | Per-lane byte select, active low |
| oe_n | input | 1 | Output enable, active low, not registered |
| bus_din | input | LANES*(BYTE_W+1) | Data and parity from the bus |
| bus_dout | output | LANES*(BYTE_W+1) | Registered read data and parity |
| bus_drv | output | 1 | High when the block should drive the bus |

## Verification
The bench aims at the edge where a processor strobe arrives together with active write inputs. A design that honoured those inputs would corrupt the old word, and the read that follows would show it. Both strobes low at once checks priority, since a design that let the controller strobe win would write there.

The cycle just after a write is watched with output enable held low. A design that drives the bus there would collide with the data the host is presenting. One-lane writes of all-ones patterns show a wrong lane mapping or a missing parity bit at once. Closing the access with the controller strobe while the chip is deselected, then sending write inputs, catches a design that keeps writing to the stale address.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  typedef enum logic [1:0] {
    START_NONE  = 2'd0,
    START_PROC  = 2'd1,
    START_CTRL  = 2'd2,
    START_DESEL = 2'd3
  } start_kind_e;
endpackage

// File: rtl/ssram_wr_decode.sv
module ssram_wr_decode #(
  parameter int LANES = 2
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] byte_sel_n,
  output logic [LANES-1:0] req_mask
);
  // global write wins over the byte path on every lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign req_mask[l] = !gw_n || (!bwe_n && !byte_sel_n[l]);
  end
endmodule

// File: rtl/ssram_access_seq.sv
module ssram_access_seq
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  req_mask,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  lane_we,
  output logic              open_q,
  output logic              wrote_q
);
  start_kind_e       kind;
  logic              open_d;
  logic              addr_en;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    if (chip_sel && !proc_strb_n)      kind = START_PROC;
    else if (chip_sel && !ctrl_strb_n) kind = START_CTRL;
    else if (!ctrl_strb_n)             kind = START_DESEL;
    else                               kind = START_NONE;
  end

  always_comb begin
    addr_en  = 1'b0;
    open_d   = open_q;
    acc_addr = addr_q;
    lane_we  = '0;
    unique case (kind)
      START_PROC: begin
        addr_en  = 1'b1;
        open_d   = 1'b1;
        acc_addr = addr;
      end
      START_CTRL: begin
        addr_en  = 1'b1;
        open_d   = 1'b1;
        acc_addr = addr;
        lane_we  = req_mask;
      end
      START_DESEL: open_d = 1'b0;
      default:     lane_we = open_q ? req_mask : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      open_q  <= 1'b0;
      wrote_q <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr;
      open_q  <= open_d;
      wrote_q <= |lane_we;
    end
  end
endmodule

// File: rtl/ssram_lane_array.sv
module ssram_lane_array #(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // read returns the word as it was before a write on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= mem[addr];
  end
endmodule

// File: rtl/ssram_wr_ctl.sv
module ssram_wr_ctl #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int BUS_W  = DATA_W + LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  byte_sel_n,
  input  logic              oe_n,
  input  logic [BUS_W-1:0]  bus_din,
  output logic [BUS_W-1:0]  bus_dout,
  output logic              bus_drv
);
  localparam int LANE_W = BYTE_W + 1;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [LANES-1:0]  req_mask;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] acc_addr;
  logic              open_q;
  logic              wrote_q;
  logic [LANE_W-1:0] lane_wd [LANES];
  logic [LANE_W-1:0] lane_rd [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  ssram_wr_decode #(.LANES(LANES)) u_dec (
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .byte_sel_n (byte_sel_n),
    .req_mask   (req_mask)
  );

  ssram_access_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .chip_sel    (chip_sel),
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .addr        (addr),
    .req_mask    (req_mask),
    .acc_addr    (acc_addr),
    .lane_we     (lane_we),
    .open_q      (open_q),
    .wrote_q     (wrote_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_wd[l] = {bus_din[DATA_W + l], bus_din[l*BYTE_W +: BYTE_W]};
    assign bus_dout[l*BYTE_W +: BYTE_W] = lane_rd[l][BYTE_W-1:0];
    assign bus_dout[DATA_W + l]         = lane_rd[l][BYTE_W];

    ssram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .we      (lane_we[l]),
      .addr    (acc_addr),
      .wdata   (lane_wd[l]),
      .rdata_q (lane_rd[l])
    );
  end

  assign bus_drv = !oe_n && open_q && !wrote_q;
endmodule

// File: rtl/ssram_wr_ctl_chk.sv
module ssram_wr_ctl_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_sel,
  input logic             proc_strb_n,
  input logic             ctrl_strb_n,
  input logic             gw_n,
  input logic             oe_n,
  input logic [LANES-1:0] req_mask,
  input logic [LANES-1:0] lane_we,
  input logic             bus_drv
);
  a_r1_gw_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !gw_n |-> (&req_mask));

  a_r4_proc_first_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && !proc_strb_n) |-> (lane_we == '0));

  a_r5_ctrl_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && proc_strb_n && !ctrl_strb_n && (|req_mask)) |-> (|lane_we));

  a_r7_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |=> !bus_drv);

  a_r8_oe_gates_drive: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !bus_drv);

  a_r9_desel_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel && !ctrl_strb_n) |=> !bus_drv);
endmodule

bind ssram_wr_ctl ssram_wr_ctl_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chip_sel    (chip_sel),
  .proc_strb_n (proc_strb_n),
  .ctrl_strb_n (ctrl_strb_n),
  .gw_n        (gw_n),
  .oe_n        (oe_n),
  .req_mask    (req_mask),
  .lane_we     (lane_we),
  .bus_drv     (bus_drv)
);

// File: tb/ssram_wr_ctl_bench.sv
`timescale 1ns/1ps
module ssram_wr_ctl_bench;
  localparam int AW = 4;
  localparam int BW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, ps_n, cs_n, gw_n, bwe_n, oe_n;
  logic [AW-1:0] addr;
  logic [1:0]    bs_n;
  logic [BW-1:0] din;
  logic [BW-1:0] dout;
  logic          drv;

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R10";

  logic [BW-1:0] m_mem [16];
  logic          m_open, m_wrote;
  logic [AW-1:0] m_addr;
  logic [BW-1:0] m_rd;

  always #4 clk = ~clk;

  ssram_wr_ctl u_ssram_wr_ctl (
    .clk(clk), .rst_n(rst_n), .chip_sel(sel), .proc_strb_n(ps_n),
    .ctrl_strb_n(cs_n), .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n),
    .byte_sel_n(bs_n), .oe_n(oe_n), .bus_din(din), .bus_dout(dout),
    .bus_drv(drv)
  );

  function automatic logic [1:0] f_mask(logic g, logic b, logic [1:0] s);
    if (!g) return 2'b11;
    if (!b) return ~s;
    return 2'b00;
  endfunction

  function automatic logic [BW-1:0] f_bits(logic [1:0] m);
    return (m[0] ? 18'h100FF : 18'h0) | (m[1] ? 18'h2FF00 : 18'h0);
  endfunction

  task automatic model_edge();
    logic [1:0]    we = 2'b00;
    logic [AW-1:0] eff = m_addr;
    logic [BW-1:0] bm;
    if (sel && !ps_n) begin
      eff = addr; m_open = 1'b1;
    end else if (sel && !cs_n) begin
      eff = addr; m_open = 1'b1; we = f_mask(gw_n, bwe_n, bs_n);
    end else if (!cs_n) begin
      m_open = 1'b0;
    end else if (m_open) begin
      we = f_mask(gw_n, bwe_n, bs_n);
    end
    m_rd    = m_mem[eff];
    bm      = f_bits(we);
    m_mem[eff] = (m_mem[eff] & ~bm) | (din & bm);
    m_addr  = eff;
    m_wrote = |we;
  endtask

  task automatic check_outputs();
    logic exp_drv = !oe_n && m_open && !m_wrote;
    checks++;
    if (drv !== exp_drv) begin
      fails++;
      $display("FAIL %s bus_drv actual=%0b expected=%0b", tag, drv, exp_drv);
    end
    if (exp_drv) begin
      checks++;
      if (dout !== m_rd) begin
        fails++;
        $display("FAIL %s bus_dout actual=%05h expected=%05h", tag, dout, m_rd);
      end
    end
  endtask

  task automatic cyc(logic s, logic p, logic c, logic [AW-1:0] a, logic g,
                     logic b, logic [1:0] bs, logic o, logic [BW-1:0] d);
    @(negedge clk);
    check_outputs();
    sel = s; ps_n = p; cs_n = c; addr = a; gw_n = g; bwe_n = b;
    bs_n = bs; oe_n = o; din = d;
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(logic o);
    cyc(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, 2'b11, o, '0);
  endtask

  task automatic rd(logic [AW-1:0] a);
    cyc(1'b1, 1'b0, 1'b1, a, 1'b1, 1'b1, 2'b11, 1'b0, '0);
    idle(1'b0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(64'd8 * 200000);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; sel = 1'b1; ps_n = 1'b1; cs_n = 1'b1; addr = '0;
    gw_n = 1'b1; bwe_n = 1'b1; bs_n = 2'b11; oe_n = 1'b0; din = '0;
    m_open = 1'b0; m_wrote = 1'b0; m_addr = '0; m_rd = '0;
    for (int i = 0; i < 16; i++) m_mem[i] = 'x;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    tag = "R10";
    repeat (4) idle(1'b0);

    tag = "R5";
    for (int i = 0; i < 16; i++)
      cyc(1'b1, 1'b1, 1'b0, AW'(i), 1'b0, 1'b1, 2'b11, 1'b0, BW'(i * 18'h1111));
    idle(1'b0);
    rd(4'd9);

    tag = "R1";
    cyc(1'b1, 1'b1, 1'b0, 4'd3, 1'b0, 1'b1, 2'b11, 1'b0, 18'h2A5C3);
    rd(4'd3);

    tag = "R2";
    cyc(1'b1, 1'b1, 1'b0, 4'd5, 1'b1, 1'b1, 2'b00, 1'b0, 18'h3FFFF);
    rd(4'd5);
    cyc(1'b1, 1'b1, 1'b0, 4'd5, 1'b1, 1'b0, 2'b10, 1'b0, 18'h3FFFF);
    rd(4'd5);

    tag = "R3";
    cyc(1'b1, 1'b1, 1'b0, 4'd6, 1'b1, 1'b0, 2'b01, 1'b0, 18'h3FFFF);
    rd(4'd6);
    cyc(1'b1, 1'b1, 1'b0, 4'd6, 1'b1, 1'b0, 2'b10, 1'b0, 18'h00000);
    rd(4'd6);

    tag = "R4";
    cyc(1'b1, 1'b0, 1'b1, 4'd7, 1'b0, 1'b0, 2'b00, 1'b0, 18'h12345);
    cyc(1'b1, 1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 2'b11, 1'b0, 18'h0BEEF);
    tag = "R7";
    idle(1'b0);
    idle(1'b0);
    tag = "R4";
    rd(4'd7);

    tag = "R6";
    cyc(1'b1, 1'b0, 1'b0, 4'd8, 1'b0, 1'b1, 2'b11, 1'b0, 18'h15555);
    idle(1'b0);
    rd(4'd8);

    tag = "R9";
    rd(4'd10);
    cyc(1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 1'b1, 2'b11, 1'b0, '0);
    idle(1'b0);
    cyc(1'b0, 1'b1, 1'b0, 4'd2, 1'b1, 1'b1, 2'b11, 1'b0, '0);
    cyc(1'b1, 1'b1, 1'b1, 4'd2, 1'b0, 1'b1, 2'b11, 1'b0, 18'h3C3C3);
    idle(1'b0);
    rd(4'd10);

    tag = "R8";
    for (int n = 0; n < 3000; n++) begin
      cyc(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
          AW'($urandom), ($urandom % 6) != 0, ($urandom % 3) != 0,
          2'($urandom), ($urandom % 4) == 0, BW'($urandom));
    end
    idle(1'b0);
    idle(1'b0);
    summary();
  end
endmodule